// File: doc/BRIEF.md
# Source Handshake Settling Delay Timer

This block measures the settling interval a bus talker must let pass between putting a byte on the parallel data lines and raising its data-valid strobe. The surrounding source handshake asks for a delay with a one-cycle start request. With that request it gives a flag marking the first byte of a transfer and three configuration bits: fast-mode, tri-state transceiver and user short-delay. It also gives a bypass bit. The timer picks a length in clock periods from those inputs, holds a busy flag while it counts, and then pulses a done output for one clock. That pulse tells the handshake that the data lines have been stable long enough.

Faster settings apply only to bytes after the first, because the first byte of a transfer has to allow for a slower bus. Bypass replaces the whole table with a wait of a few clocks, for systems whose clock period alone already covers the settling time. An abort input ends any delay at once and no done pulse follows it.

Top module: `sdly_settle_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy_o` and `done_o` are both 0.
- R2: With the configuration bits {fast, tri, short} = 3'b000, the delay is 40 clocks for first and later bytes alike.
- R3: With {fast, tri, short} = 3'b001, the delay is 22 clocks for every byte.
- R4: With {fast, tri, short} = 3'b010, the delay is 40 clocks when `first_i` is 1 and 10 clocks otherwise.
- R5: With {fast, tri, short} = 3'b011, the delay is 22 clocks on a first byte and 7 clocks otherwise.
- R6: With {fast, tri, short} = 3'b111, the delay is 22 clocks on a first byte and 4 clocks otherwise.
- R7: Each remaining combination (3'b100, 3'b101, 3'b110) gives 40 clocks for every byte.
- R8: When `bypass_i` is 1 at acceptance, the delay is 2 clocks and the three configuration bits and `first_i` have no effect.
- R9: The configuration, first-byte and bypass inputs are sampled only in the cycle a start is accepted. Changing them while a delay is running does not change its length.
- R10: A start is accepted when `start_i` is 1, `busy_o` is 0 and `abort_i` is 0. A start request while `busy_o` is 1 is ignored.
- R11: For a delay of N clocks accepted at clock edge k, `busy_o` is 1 after edges k through k+N-1. `done_o` is 1 only after edge k+N, for exactly one cycle, and it never overlaps `busy_o`.
- R12: `abort_i` = 1 at a clock edge clears `busy_o` and `done_o` after that edge, blocks acceptance at that edge, and no done pulse follows for the aborted delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all delays count its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a settling delay |
| first_i | input | 1 | The byte being sourced is the first of its transfer |
| cfg_fast_i | input | 1 | Fast-mode configuration bit |
| cfg_tri_i | input | 1 | Tri-state transceiver configuration bit |
| cfg_short_i | input | 1 | User short-delay configuration bit |
| bypass_i | input | 1 | Replace the table with the short fixed wait |
| abort_i | input | 1 | Cancel the running delay without a done pulse |
| busy_o | output | 1 | A delay is being counted |
| done_o | output | 1 | One-cycle pulse: data-valid may now be asserted |

## Verification
All eight configuration codes are run with both values of the first-byte flag. This shows whether the table tells the first byte from later ones, and whether the unlisted codes fall back to the long setting and do not borrow a neighbour's row. Bypass is run with configuration codes that would otherwise give both long and short delays, to show that the table is really overridden. Some runs change the inputs or repeat the start request while the count is under way, which separates sampling at acceptance from live decoding. Aborts during a run and on the same cycle as a start show that the counter is cleared and that no late done pulse escapes.

// File: rtl/sdly_pkg.sv
// Package sdly_pkg
// Shared types and the code-to-profile mapping for the settling delay timer.
// Assumes the three configuration bits arrive as plain levels.
package sdly_pkg;

    // Configuration bits as seen at the moment a start is accepted.
    typedef struct packed {
        logic fast;
        logic tri_xcvr;
        logic short_dly;
    } sdly_cfg_t;

    // Delay profiles; each one has a first-byte and a later-byte length.
    typedef enum logic [2:0] {
        PROF_BASE      = 3'd0,
        PROF_SHORT     = 3'd1,
        PROF_TRI       = 3'd2,
        PROF_TRI_SHORT = 3'd3,
        PROF_FAST      = 3'd4
    } sdly_prof_t;

    // Map the configuration code to a profile; unlisted codes fall back to base.
    function automatic sdly_prof_t sdly_classify(input sdly_cfg_t c);
        sdly_prof_t p;
        case ({c.fast, c.tri_xcvr, c.short_dly})
            3'b001:  p = PROF_SHORT;
            3'b010:  p = PROF_TRI;
            3'b011:  p = PROF_TRI_SHORT;
            3'b111:  p = PROF_FAST;
            default: p = PROF_BASE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdly_table.sv
// Module sdly_table
// Picks the delay length from the profile, the first-byte flag and bypass.
// It is purely combinational, and its output is only used in the cycle of
// acceptance. The output is the tick count minus one, which is the value
// the down counter is loaded with. Assumes every tick parameter is at least 1.
module sdly_table
    import sdly_pkg::*;
#(
    parameter int LONG_TICKS       = 40,
    parameter int MID_TICKS        = 22,
    parameter int TRI_NEXT_TICKS   = 10,
    parameter int SHORT_NEXT_TICKS = 7,
    parameter int FAST_NEXT_TICKS  = 4,
    parameter int BYPASS_TICKS     = 2,
    parameter int CW               = 6
) (
    input  sdly_cfg_t       cfg_i,
    input  logic            first_i,
    input  logic            bypass_i,
    output logic [CW-1:0]   load_o
);

    localparam logic [CW-1:0] L_LONG  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] L_MID   = CW'(MID_TICKS - 1);
    localparam logic [CW-1:0] L_TRI   = CW'(TRI_NEXT_TICKS - 1);
    localparam logic [CW-1:0] L_SHORT = CW'(SHORT_NEXT_TICKS - 1);
    localparam logic [CW-1:0] L_FAST  = CW'(FAST_NEXT_TICKS - 1);
    localparam logic [CW-1:0] L_BYP   = CW'(BYPASS_TICKS - 1);

    sdly_prof_t    prof;
    logic [CW-1:0] first_len;
    logic [CW-1:0] next_len;

    // Classify the configuration code into a profile.
    assign prof = sdly_classify(cfg_i);

    // Per-profile lengths for a first byte and for the bytes after it.
    always_comb begin
        case (prof)
            PROF_SHORT: begin
                first_len = L_MID;
                next_len  = L_MID;
            end
            PROF_TRI: begin
                first_len = L_LONG;
                next_len  = L_TRI;
            end
            PROF_TRI_SHORT: begin
                first_len = L_MID;
                next_len  = L_SHORT;
            end
            PROF_FAST: begin
                first_len = L_MID;
                next_len  = L_FAST;
            end
            default: begin
                first_len = L_LONG;
                next_len  = L_LONG;
            end
        endcase
    end

    // Bypass overrides the table; otherwise the first-byte flag picks the column.
    always_comb begin
        if (bypass_i)
            load_o = L_BYP;
        else if (first_i)
            load_o = first_len;
        else
            load_o = next_len;
    end

endmodule

// File: rtl/sdly_counter.sv
// Module sdly_counter
// Down counter with a synchronous clear, a load and a decrement enable.
// Clear has priority over load, and load has priority over the decrement.
// It stops at zero and reports zero on a flag.
module sdly_counter #(
    parameter int CW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            load_i,
    input  logic [CW-1:0]   load_val_i,
    input  logic            dec_i,
    output logic            zero_o
);

    logic [CW-1:0] cnt_q;

    // Count register: clear, load, or step down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Zero flag for the controller.
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdly_ctrl.sv
// Module sdly_ctrl
// Holds the busy and done state, decides when a start is accepted, and
// drives the counter's load, decrement and clear. Abort wins over every
// other input. Assumes the counter reaches zero on the last busy cycle.
module sdly_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic cnt_zero_i,
    output logic accept_o,
    output logic dec_o,
    output logic clear_o,
    output logic busy_o,
    output logic done_o
);

    logic busy_q;
    logic done_q;
    logic finish;

    // A start is taken only while idle and not aborting.
    assign accept_o = start_i && !busy_q && !abort_i;
    // The last busy cycle is the one where the counter already reads zero.
    assign finish   = busy_q && cnt_zero_i && !abort_i;
    // Step the counter while busy; empty it on abort.
    assign dec_o    = busy_q && !abort_i;
    assign clear_o  = abort_i;

    // Busy flag: set on acceptance, cleared on finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i)
            busy_q <= 1'b0;
        else if (accept_o)
            busy_q <= 1'b1;
        else if (finish)
            busy_q <= 1'b0;
    end

    // Done pulse: one cycle after the last busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i)
            done_q <= 1'b0;
        else
            done_q <= finish;
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/sdly_settle_timer.sv
// Module sdly_settle_timer
// Top level of the settling delay timer. The delay length is decoded from
// the live inputs and loaded into the counter in the cycle of acceptance,
// so later input changes cannot alter a running delay. Assumes a single
// clock domain and inputs that are synchronous to clk.
module sdly_settle_timer
    import sdly_pkg::*;
#(
    parameter int LONG_TICKS       = 40,
    parameter int MID_TICKS        = 22,
    parameter int TRI_NEXT_TICKS   = 10,
    parameter int SHORT_NEXT_TICKS = 7,
    parameter int FAST_NEXT_TICKS  = 4,
    parameter int BYPASS_TICKS     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic first_i,
    input  logic cfg_fast_i,
    input  logic cfg_tri_i,
    input  logic cfg_short_i,
    input  logic bypass_i,
    input  logic abort_i,
    output logic busy_o,
    output logic done_o
);

    localparam int MAX_TICKS = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
    localparam int CW        = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

    sdly_cfg_t     cfg;
    logic [CW-1:0] load_val;
    logic          accept;
    logic          dec;
    logic          clear;
    logic          zero;

    // Bundle the configuration pins.
    assign cfg = '{fast: cfg_fast_i, tri_xcvr: cfg_tri_i, short_dly: cfg_short_i};

    sdly_table #(
        .LONG_TICKS       (LONG_TICKS),
        .MID_TICKS        (MID_TICKS),
        .TRI_NEXT_TICKS   (TRI_NEXT_TICKS),
        .SHORT_NEXT_TICKS (SHORT_NEXT_TICKS),
        .FAST_NEXT_TICKS  (FAST_NEXT_TICKS),
        .BYPASS_TICKS     (BYPASS_TICKS),
        .CW               (CW)
    ) u_table (
        .cfg_i    (cfg),
        .first_i  (first_i),
        .bypass_i (bypass_i),
        .load_o   (load_val)
    );

    sdly_counter #(
        .CW (CW)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .load_i     (accept),
        .load_val_i (load_val),
        .dec_i      (dec),
        .zero_o     (zero)
    );

    sdly_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .abort_i    (abort_i),
        .cnt_zero_i (zero),
        .accept_o   (accept),
        .dec_o      (dec),
        .clear_o    (clear),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/sdly_settle_timer_chk.sv
// Module sdly_settle_timer_chk
// Port-level checker for the settling delay timer, bound to the top module.
// It measures each busy run with its own counter, so no long $past is needed.
module sdly_settle_timer_chk #(
    parameter int LONG_TICKS   = 40,
    parameter int BYPASS_TICKS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic bypass_i,
    input logic abort_i,
    input logic busy_o,
    input logic done_o
);

    logic       accept;
    logic       byp_q;
    logic [7:0] run_q;

    assign accept = start_i && !busy_o && !abort_i;

    // Length of the current busy run, starting at 1 on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (accept)
            run_q <= 8'd1;
        else if (busy_o && run_q != 8'hff)
            run_q <= run_q + 8'd1;
        else if (!busy_o)
            run_q <= '0;
    end

    // Remember whether the current run was started in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byp_q <= 1'b0;
        else if (accept)
            byp_q <= bypass_i;
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    a_r12_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o));

    a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q <= 8'(LONG_TICKS)));

    a_r8_bypass_short: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && byp_q) |-> (run_q <= 8'(BYPASS_TICKS)));

endmodule

bind sdly_settle_timer sdly_settle_timer_chk #(
    .LONG_TICKS   (LONG_TICKS),
    .BYPASS_TICKS (BYPASS_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bypass_i (bypass_i),
    .abort_i  (abort_i),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/tb_sdly_settle_timer.sv
module tb_sdly_settle_timer;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, first_i = 0, cfg_fast_i = 0, cfg_tri_i = 0, cfg_short_i = 0;
    logic bypass_i = 0, abort_i = 0;
    logic busy_o, done_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdly_settle_timer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i),
        .cfg_fast_i(cfg_fast_i), .cfg_tri_i(cfg_tri_i), .cfg_short_i(cfg_short_i),
        .bypass_i(bypass_i), .abort_i(abort_i), .busy_o(busy_o), .done_o(done_o)
    );

    // Expected length from the requirement table.
    function automatic int exp_ticks(input bit f, input bit t, input bit s,
                                     input bit first, input bit byp);
        if (byp) return 2;                              // R8
        case ({f, t, s})
            3'b000: return 40;                          // R2
            3'b001: return 22;                          // R3
            3'b010: return first ? 40 : 10;             // R4
            3'b011: return first ? 22 : 7;              // R5
            3'b111: return first ? 22 : 4;              // R6
            default: return 40;                         // R7
        endcase
    endfunction

    // Behavioural reference model, updated on every rising edge.
    bit m_busy = 0, m_done = 0;
    int m_rem  = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rem = 0;
        end else if (abort_i) begin
            m_busy = 0; m_done = 0;
        end else if (m_busy) begin
            if (m_rem == 1) begin m_busy = 0; m_done = 1; end
            else begin m_rem = m_rem - 1; m_done = 0; end
        end else begin
            m_done = 0;
            if (start_i) begin
                m_busy = 1;
                m_rem  = exp_ticks(cfg_fast_i, cfg_tri_i, cfg_short_i, first_i, bypass_i);
            end
        end
    end

    // Compare outputs with the model a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        checks++;
        if (busy_o !== m_busy || done_o !== m_done) begin
            fails++;
            $display("FAIL R11 model compare: busy=%0b done=%0b expected busy=%0b done=%0b",
                     busy_o, done_o, m_busy, m_done);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one delay and measure edges from acceptance to the done pulse.
    // With chg set, inputs are flipped and start is held during the run.
    task automatic run_delay(input bit f, input bit t, input bit s, input bit first,
                             input bit byp, input bit chg, input string req);
        int n;
        int exp;
        exp = exp_ticks(f, t, s, first, byp);
        @(negedge clk);
        cfg_fast_i = f; cfg_tri_i = t; cfg_short_i = s; first_i = first; bypass_i = byp;
        start_i = 1;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        if (chg) begin
            cfg_fast_i = ~f; cfg_tri_i = ~t; cfg_short_i = ~s; first_i = ~first; bypass_i = ~byp;
        end else start_i = 0;
        while (!done_o && n < 100) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (chg && n == 3) start_i = 0;
        end
        start_i = 0;
        check(n == exp, req, n, exp);
        @(negedge clk);
        check(!done_o && !busy_o, "R11 single done", done_o, 0);
        bypass_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R1 reset idle", busy_o, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1 after reset", done_o, 0);

        for (int fb = 0; fb < 2; fb++) begin
            run_delay(0, 0, 0, fb[0], 0, 0, "R2 base");
            run_delay(0, 0, 1, fb[0], 0, 0, "R3 short only");
            run_delay(0, 1, 0, fb[0], 0, 0, "R4 tri only");
            run_delay(0, 1, 1, fb[0], 0, 0, "R5 tri+short");
            run_delay(1, 1, 1, fb[0], 0, 0, "R6 all set");
            run_delay(1, 0, 0, fb[0], 0, 0, "R7 code 100");
            run_delay(1, 0, 1, fb[0], 0, 0, "R7 code 101");
            run_delay(1, 1, 0, fb[0], 0, 0, "R7 code 110");
            run_delay(0, 0, 0, fb[0], 1, 0, "R8 bypass over long");
            run_delay(1, 1, 1, fb[0], 1, 0, "R8 bypass over fast");
        end
        // R9 and R10: inputs flipped and start held while running.
        run_delay(0, 0, 0, 1, 0, 1, "R9 R10 base held");
        run_delay(1, 1, 1, 0, 0, 1, "R9 R10 fast held");
        run_delay(0, 1, 0, 0, 0, 1, "R9 tri later held");

        // R12: abort in mid-run, then no done for a long window.
        @(negedge clk);
        cfg_fast_i = 0; cfg_tri_i = 0; cfg_short_i = 0; first_i = 1; start_i = 1;
        @(negedge clk); start_i = 0;
        repeat (10) @(negedge clk);
        check(busy_o, "R12 busy before abort", busy_o, 1);
        abort_i = 1;
        @(negedge clk); abort_i = 0;
        check(!busy_o && !done_o, "R12 abort clears", busy_o, 0);
        begin
            int seen = 0;
            repeat (50) begin @(negedge clk); if (done_o) seen++; end
            check(seen == 0, "R12 no late done", seen, 0);
        end
        // R12: abort together with start blocks acceptance.
        start_i = 1; abort_i = 1;
        @(negedge clk); start_i = 0; abort_i = 0;
        check(!busy_o, "R12 abort blocks start", busy_o, 0);
        run_delay(0, 1, 1, 0, 0, 0, "R5 after abort");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule